// File: doc/BRIEF.md
# Serial Port FIFO Error and Interrupt Controller

This block sits between a CPU register bus and a frame-synchronised serial word shifter. Software or a DMA engine writes words into a 16-entry transmit queue and reads words from a 16-entry receive queue. On each serial word strobe, the shifter takes one transmit word and delivers one received word in the same cycle. Two fill-level thresholds drive a transmit and a receive data request. Each request is registered into a flag. The flag goes to a DMA request pin for its direction and can also raise the interrupt line.

Every error has a fixed recovery action, so the serial stream keeps running after a fault. A transmit underrun repeats the previous word. A write into a full transmit queue is dropped. A received word that finds the queue full is discarded. A read of an empty receive queue returns the last word read. A frame-sync pulse that arrives early or late realigns the slot counter. Each error sets a sticky status bit, and software clears the bit by writing 1 to it. A per-source enable mask decides which status bits drive the interrupt.

Top module: `serial_fifo_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty and all error bits are 0. The enable mask is 0, the transmit threshold is 0 and the receive threshold is 1. The serial output word is 0 and both request pins are low.
- R2: Words written to address 0 leave on `ser_tx_data` in write order. The output register updates at the clock edge that samples `ser_word`.
- R3: A word strobe with an empty transmit queue leaves `ser_tx_data` unchanged, so the previous word is repeated. It also sets status bit 2.
- R4: A write to address 0 while the transmit queue holds 16 words is dropped. The queue contents and level stay unchanged, and status bit 3 is set. Fullness is judged on the level at the start of the cycle.
- R5: Received words are returned by reads of address 1 in arrival order. Each such read removes one word.
- R6: A received word that arrives while the receive queue holds 16 words is discarded, and status bit 4 is set.
- R7: A read of address 1 with an empty receive queue returns the last word read from the queue, and status bit 5 is set.
- R8: `fsync` marks slot 0. The counter advances on each word strobe and saturates at 4 (`SLOTS`). A pulse while the counter is below 4 sets status bit 6. Every pulse resets the counter to 0, so the next frame of 4 words followed by a pulse raises no error.
- R9: Status bit 0 (`tx_dreq`) becomes 1 one cycle after the transmit level is at or below the transmit threshold (address 4, bits 4:0). It is 0 in the cycle after that condition ends or after `tx_dack` is sampled high.
- R10: Status bit 1 (`rx_dreq`) becomes 1 one cycle after the receive level is at or above the receive threshold (address 4, bits 12:8). It is 0 in the cycle after that condition ends or after `rx_dack` is sampled high.
- R11: Error bits 6:2 stay set until a write to address 2 with a 1 in that bit. If a clear and a new error for the same bit land in one cycle, the bit stays set.
- R12: `irq` is 1 only when some status bit 6:0 is 1 and the same bit of the enable mask (address 3) is 1. Reads of address 5 return the transmit level in bits 4:0 and the receive level in bits 12:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tx_dreq | output | 1 | Transmit data request flag |
| tx_dack | input | 1 | Transmit DMA acknowledge |
| rx_dreq | output | 1 | Receive data request flag |
| rx_dack | input | 1 | Receive DMA acknowledge |
| ser_word | input | 1 | Serial word strobe: pop transmit, push receive |
| ser_rx_data | input | 32 | Word delivered by the shifter |
| ser_tx_data | output | 32 | Word handed to the shifter |
| fsync | input | 1 | Frame-sync pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a status clear and a new error for the same bit in the same cycle. The stimulus drives a write-1-clear of bit 2 in the same cycle as a word strobe on an empty transmit queue, then reads bit 2 back.

Receive overrun also takes setup. The queue is never drained during the transmit tests, so the 22 word strobes those tests issue overflow it. The bench's receive model then predicts which 16 words survive.

// File: rtl/sfc_pkg.sv
// Shared register addresses and status bit positions for the serial FIFO controller.
package sfc_pkg;
    localparam logic [2:0] A_TXD  = 3'd0;
    localparam logic [2:0] A_RXD  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_EN   = 3'd3;
    localparam logic [2:0] A_THR  = 3'd4;
    localparam logic [2:0] A_LVL  = 3'd5;
    // error vector order inside the status register, starting at bit 2
    localparam int E_TXU  = 0;
    localparam int E_TXO  = 1;
    localparam int E_RXO  = 2;
    localparam int E_RXU  = 3;
    localparam int E_SYNC = 4;
    localparam int NERR   = 5;
    localparam int NSRC   = NERR + 2;
endpackage

// File: rtl/sfc_fifo.sv
// Synchronous FIFO with head-of-queue output.
// Assumes: a push into a full queue and a pop from an empty queue are ignored here;
// the caller flags them as errors.
module sfc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // storage write; memory needs no reset
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R4
    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full); // R4
endmodule

// File: rtl/sfc_dreq.sv
// Data request flag: follows the request condition with one cycle of delay,
// and drops for one cycle after a DMA acknowledge.
module sfc_dreq (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic dack,
    output logic flag
);
    // register the request, cancelled by an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= req && !dack;
    end

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> !flag); // R9
    AST_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !flag); // R10
endmodule

// File: rtl/sfc_slot.sv
// Frame slot counter: fsync marks slot 0, each word strobe advances, saturating at SLOTS.
// Assumes: a sync pulse is legal only when the counter sits at SLOTS.
module sfc_slot #(
    parameter int SLOTS = 4,
    localparam int SW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          sync,
    output logic          err,
    output logic [SW-1:0] cnt
);
    assign err = sync && (cnt != SW'(SLOTS));

    // realign on sync, otherwise count words up to the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= SW'(SLOTS);
        else if (sync)                      cnt <= '0;
        else if (strobe && cnt != SW'(SLOTS)) cnt <= cnt + 1'b1;
    end

    AST_SYNC_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> cnt == '0); // R8
endmodule

// File: rtl/sfc_status.sv
// Sticky error bits with write-1-to-clear, and the masked interrupt reduction.
// Assumes: set and clear arrive as one-cycle pulses; set wins over clear.
module sfc_status #(
    parameter int NE = 5,
    localparam int NS = NE + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] set,
    input  logic [NE-1:0] clr,
    input  logic [1:0]    flags,
    input  logic [NS-1:0] en,
    output logic [NE-1:0] err,
    output logic          irq
);
    for (genvar i = 0; i < NE; i++) begin : g_bit
        // one sticky bit: set has priority over a same-cycle clear
        always_ff @(posedge clk) begin
            if (!rst_n)      err[i] <= 1'b0;
            else if (set[i]) err[i] <= 1'b1;
            else if (clr[i]) err[i] <= 1'b0;
        end

        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            err[i] && !clr[i] |=> err[i]); // R11
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> err[i]); // R11
    end

    // interrupt: any enabled source that is active
    always_comb irq = |({err, flags} & en);
endmodule

// File: rtl/serial_fifo_ctrl.sv
// Serial port FIFO controller: register decode, transmit and receive queues,
// error recovery actions, request flags and interrupt.
// Assumes: one bus access per cycle; bus_rdata is combinational; ser_word moves one
// transmit word out and one receive word in during the same cycle.
module serial_fifo_ctrl
    import sfc_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int SLOTS = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [2:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         tx_dreq,
    input  logic         tx_dack,
    output logic         rx_dreq,
    input  logic         rx_dack,
    input  logic         ser_word,
    input  logic [W-1:0] ser_rx_data,
    output logic [W-1:0] ser_tx_data,
    input  logic         fsync,
    output logic         irq
);
    localparam int SW = $clog2(SLOTS + 1);

    logic            wr_tx, rd_rx, wr_stat, wr_en, wr_thr;
    logic [W-1:0]    tx_head, rx_head, last_rd;
    logic [CW-1:0]   tx_cnt, rx_cnt, tx_thr, rx_thr;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic [NSRC-1:0] irq_en;
    logic [NERR-1:0] err_set, err_clr, err;
    logic            sync_err;
    logic [SW-1:0]   slot_cnt;

    // access decode
    always_comb begin
        wr_tx   = bus_sel &&  bus_wr && bus_addr == A_TXD;
        rd_rx   = bus_sel && !bus_wr && bus_addr == A_RXD;
        wr_stat = bus_sel &&  bus_wr && bus_addr == A_STAT;
        wr_en   = bus_sel &&  bus_wr && bus_addr == A_EN;
        wr_thr  = bus_sel &&  bus_wr && bus_addr == A_THR;
    end

    sfc_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_tx), .pop(ser_word), .wdata(bus_wdata),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    sfc_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(ser_word), .pop(rd_rx), .wdata(ser_rx_data),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    sfc_slot #(.SLOTS(SLOTS)) u_slot (
        .clk(clk), .rst_n(rst_n), .strobe(ser_word), .sync(fsync),
        .err(sync_err), .cnt(slot_cnt));

    // serial output word: refreshed from the queue, held on underrun
    always_ff @(posedge clk) begin
        if (!rst_n)                    ser_tx_data <= '0;
        else if (ser_word && !tx_empty) ser_tx_data <= tx_head;
    end

    // last word taken from the receive queue, replayed on underrun
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_rd <= '0;
        else if (rd_rx && !rx_empty) last_rd <= rx_head;
    end

    // control registers: enable mask and thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
            tx_thr <= '0;
            rx_thr <= CW'(1);
        end else begin
            if (wr_en) irq_en <= bus_wdata[NSRC-1:0];
            if (wr_thr) begin
                tx_thr <= bus_wdata[CW-1:0];
                rx_thr <= bus_wdata[8 +: CW];
            end
        end
    end

    // error events and write-1 clears
    always_comb begin
        err_set         = '0;
        err_set[E_TXU]  = ser_word && tx_empty;
        err_set[E_TXO]  = wr_tx && tx_full;
        err_set[E_RXO]  = ser_word && rx_full;
        err_set[E_RXU]  = rd_rx && rx_empty;
        err_set[E_SYNC] = sync_err;
        err_clr         = wr_stat ? bus_wdata[2 +: NERR] : '0;
    end

    sfc_dreq u_txreq (.clk(clk), .rst_n(rst_n), .req(tx_cnt <= tx_thr),
        .dack(tx_dack), .flag(tx_dreq));
    sfc_dreq u_rxreq (.clk(clk), .rst_n(rst_n), .req(rx_cnt >= rx_thr),
        .dack(rx_dack), .flag(rx_dreq));

    sfc_status #(.NE(NERR)) u_stat (
        .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr),
        .flags({rx_dreq, tx_dreq}), .en(irq_en), .err(err), .irq(irq));

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RXD:  bus_rdata = rx_empty ? last_rd : rx_head;
            A_STAT: bus_rdata = W'({err, rx_dreq, tx_dreq});
            A_EN:   bus_rdata = W'(irq_en);
            A_THR:  bus_rdata = W'(tx_thr) | (W'(rx_thr) << 8);
            A_LVL:  bus_rdata = W'(tx_cnt) | (W'(rx_cnt) << 8);
            default: bus_rdata = '0;
        endcase
    end

    AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ser_word && tx_empty |=> $stable(ser_tx_data)); // R3
    AST_OVERRUN_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx && tx_full && !ser_word |=> tx_cnt == CW'(DEPTH)); // R4
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en == '0 |-> !irq); // R12
    AST_SLOT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cnt <= SW'(SLOTS)); // R8
endmodule

// File: tb/sim_serial_fifo_ctrl.sv
module sim_serial_fifo_ctrl;
    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        tx_dreq, tx_dack = 0, rx_dreq, rx_dack = 0;
    logic        ser_word = 0, fsync = 0, irq;
    logic [31:0] ser_rx_data = 0, ser_tx_data;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] exp_tx [$];
    logic [31:0] tx_model [$];
    logic [31:0] rx_model [$];
    logic [31:0] last_sent = 0, last_read = 0, rd;

    always #2 clk = ~clk;

    serial_fifo_ctrl u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        if (a == 3'd0 && tx_model.size() < 16) tx_model.push_back(d);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    // driver: one serial word; pushes the expected transmit word for the monitor
    task automatic ser_step(input logic [31:0] rxd);
        @(negedge clk);
        ser_word = 1; ser_rx_data = rxd;
        if (tx_model.size() > 0) last_sent = tx_model.pop_front();
        exp_tx.push_back(last_sent);
        if (rx_model.size() < 16) rx_model.push_back(rxd);
        @(negedge clk);
        ser_word = 0;
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        fsync = 1;
        @(negedge clk);
        fsync = 0;
    endtask

    // monitor: compares the serial output just after each strobed edge (R2, R3)
    always @(posedge clk) begin
        if (ser_word && rst_n) begin
            #1;
            if (exp_tx.size() > 0) begin
                logic [31:0] e;
                e = exp_tx.pop_front();
                chk(ser_tx_data == e, "R2/R3 tx word", ser_tx_data, e);
            end
        end
    end

    initial begin
        #(4 * 100000);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1;
        #1;
        chk(tx_dreq == 0 && rx_dreq == 0 && irq == 0, "R1 outputs", {tx_dreq, rx_dreq, irq}, 0);
        chk(ser_tx_data == 0, "R1 ser_tx_data", ser_tx_data, 0);
        bus_read(3'd2, rd); chk((rd & 32'h7C) == 0, "R1 status", rd, 0);
        bus_read(3'd5, rd); chk(rd == 0, "R1 levels", rd, 0);
        bus_read(3'd4, rd); chk(rd == 32'h100, "R1 thresholds", rd, 32'h100);
        bus_read(3'd3, rd); chk(rd == 0, "R1 enable", rd, 0);

        // R9: empty and threshold 0 -> request
        wait_cyc(2); #1 chk(tx_dreq == 1, "R9 tx_dreq empty", tx_dreq, 1);
        bus_write(3'd0, 32'h1111_0001);
        wait_cyc(2); #1 chk(tx_dreq == 0, "R9 tx_dreq above thr", tx_dreq, 0);
        bus_write(3'd4, 32'h104);
        wait_cyc(2); #1 chk(tx_dreq == 1, "R9 tx_dreq thr 4", tx_dreq, 1);
        @(negedge clk); tx_dack = 1;
        @(posedge clk); #1 chk(tx_dreq == 0, "R9 ack drops", tx_dreq, 0);
        @(negedge clk); tx_dack = 0;
        @(posedge clk); #1 chk(tx_dreq == 1, "R9 re-raise", tx_dreq, 1);

        // R2: ordering
        for (int i = 2; i <= 4; i++) bus_write(3'd0, 32'h1111_0000 + i);
        for (int i = 0; i < 4; i++) ser_step(32'hA000_0000 + i);
        // R3: underrun repeats previous word
        ser_step(32'hA000_0004);
        bus_read(3'd2, rd); chk(rd[2] == 1, "R3 underrun bit", rd, 32'h4);

        // R11: clear in same cycle as new underrun leaves bit set
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 32'h4;
        ser_word = 1; ser_rx_data = 32'hA000_0005;
        exp_tx.push_back(last_sent);
        if (rx_model.size() < 16) rx_model.push_back(32'hA000_0005);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; ser_word = 0;
        bus_read(3'd2, rd); chk(rd[2] == 1, "R11 set wins", rd, 32'h4);
        bus_write(3'd2, 32'h4);
        bus_read(3'd2, rd); chk(rd[2] == 0, "R11 w1c", rd, 0);

        // R4: fill, overflow write dropped
        for (int i = 0; i < 16; i++) bus_write(3'd0, 32'h2000_0000 + i);
        bus_read(3'd5, rd); chk(rd[4:0] == 16, "R4 full level", rd, 16);
        bus_write(3'd0, 32'h0000_0BAD);
        bus_read(3'd2, rd); chk(rd[3] == 1, "R4 overrun bit", rd, 32'h8);
        bus_read(3'd5, rd); chk(rd[4:0] == 16, "R4 level kept", rd, 16);
        for (int i = 0; i < 16; i++) ser_step(32'hB000_0000 + i);

        // R6: 22 strobes into a 16-word receive queue
        bus_read(3'd2, rd); chk(rd[4] == 1, "R6 rx overrun bit", rd, 32'h10);
        bus_read(3'd5, rd); chk(rd[12:8] == 16, "R12 rx level", rd, 32'h1000);
        // R5: receive order
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            e = rx_model.pop_front();
            bus_read(3'd1, rd); chk(rd == e, "R5 rx word", rd, e);
            last_read = e;
        end
        // R7: empty read replays
        bus_read(3'd1, rd); chk(rd == last_read, "R7 replay", rd, last_read);
        bus_read(3'd2, rd); chk(rd[5] == 1, "R7 underrun bit", rd, 32'h20);

        // R10: receive request
        wait_cyc(2); #1 chk(rx_dreq == 0, "R10 empty", rx_dreq, 0);
        ser_step(32'hC000_0000);
        wait_cyc(1); #1 chk(rx_dreq == 1, "R10 level 1", rx_dreq, 1);
        @(negedge clk); rx_dack = 1;
        @(posedge clk); #1 chk(rx_dreq == 0, "R10 ack drops", rx_dreq, 0);
        @(negedge clk); rx_dack = 0;
        bus_write(3'd4, 32'h304);
        wait_cyc(2); #1 chk(rx_dreq == 0, "R10 thr 3", rx_dreq, 0);

        // R8: frame sync
        sync_pulse();
        ser_step(32'hD000_0000); ser_step(32'hD000_0001);
        bus_read(3'd2, rd); chk(rd[6] == 0, "R8 aligned sync", rd, 0);
        sync_pulse();
        bus_read(3'd2, rd); chk(rd[6] == 1, "R8 early sync", rd, 32'h40);
        bus_write(3'd2, 32'h40);
        for (int i = 0; i < 4; i++) ser_step(32'hD100_0000 + i);
        sync_pulse();
        bus_read(3'd2, rd); chk(rd[6] == 0, "R8 realigned", rd, 0);

        // R12: interrupt gating
        #1 chk(irq == 0, "R12 no enable", irq, 0);
        ser_step(32'hE000_0000);
        sync_pulse();
        bus_write(3'd3, 32'h40);
        #1 chk(irq == 1, "R12 enabled sync", irq, 1);
        bus_write(3'd2, 32'h40);
        #1 chk(irq == 0, "R12 source cleared", irq, 0);
        bus_write(3'd3, 32'h1);
        #1 chk(irq == tx_dreq && tx_dreq == 1, "R12 tx flag source", irq, 1);

        wait_cyc(2);
        chk(exp_tx.size() == 0, "R2 monitor drained", exp_tx.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule